// File: doc/BRIEF.md
# Scatter-Plot Overlay Stream Generator

This block paints one video frame of a scatter plot as a stream of 32-bit pixels, without any frame store behind it. Each pixel is computed on the fly from a short table of point coordinates. A pixel lies inside the square marker of a point when its horizontal and vertical distances to that point are both below the marker size. Such a pixel takes the programmed marker colour at full opacity. Every other pixel is fully transparent, so a later stage can blend the overlay onto a background. A full frame at 640 by 480 with 12-bit colour does not fit in on-chip memory, while a table of twenty coordinate pairs does.

Software, through a register slave that lies outside this block, programs the frame dimensions, the point coordinates with a per-point enable, the marker size and the marker colour. It then pulses a start input. The block copies all settings at that moment and scans rows in the outer loop and columns in the inner loop. The first pixel of the frame carries a start-of-frame flag, and the last pixel of every line carries an end-of-line flag. The block honours backpressure from the consumer and raises a done flag once the final pixel has been taken.

Top module: `scatterOverlay`

## Requirements
- R1: After reset, mTvalid, mTuser, mTlast and done are all low.
- R2: A start pulse while idle, with rowCnt and colCnt both non-zero, launches a frame. The first pixel is valid in the cycle after the start edge, and the frame holds exactly rowCnt times colCnt pixels. mTuser is high only on the first pixel, at row 0 and column 0.
- R3: mTlast is high on the pixel at column colCnt-1 of every row and low on every other pixel.
- R4: Pixels leave in raster order. Row 0 comes first, and within a row the column index rises from 0.
- R5: A pixel at (col, row) is a hit when, for some enabled point (px, py), |col-px| < markSize and |row-py| < markSize. A hit pixel is {8'hFF, markColour}: alpha in bits 31:24, red in 23:16, green in 15:8, blue in 7:0. Any other pixel is 32'h0. Markers clip at the frame edges and never wrap.
- R6: A markSize of 0 produces no hit pixels.
- R7: A point with px >= colCnt or py >= rowCnt, or with its ptEnable bit low, contributes no hit pixels, even where its marker would reach into the frame.
- R8: While mTvalid is high and mTready is low, mTdata, mTuser and mTlast hold their values and the scan does not advance.
- R9: All register inputs are captured on the start edge. Changes made during a frame first take effect in the next frame.
- R10: done rises in the cycle after the final pixel is accepted, with mTvalid low. It stays high until the next accepted start clears it.
- R11: A start pulse during a frame, or with rowCnt or colCnt equal to zero, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle frame launch request |
| rowCnt | input | COORD_W | Lines per frame |
| colCnt | input | COORD_W | Pixels per line |
| ptXFlat | input | NUM_PTS*COORD_W | Point column coordinates, point i at bits i*COORD_W upward |
| ptYFlat | input | NUM_PTS*COORD_W | Point row coordinates, same packing |
| ptEnable | input | NUM_PTS | Per-point enable |
| markSize | input | COORD_W | Marker half-extent bound |
| markColour | input | 3*CHAN_W | Marker RGB, red in the top byte |
| mTdata | output | 4*CHAN_W | Pixel: alpha, red, green, blue |
| mTvalid | output | 1 | Pixel valid |
| mTready | input | 1 | Consumer accepts the pixel |
| mTuser | output | 1 | Start-of-frame flag |
| mTlast | output | 1 | End-of-line flag |
| done | output | 1 | Frame completed |

## Verification
The assertions assume a consumer that may drop mTready at any cycle but never needs more than the standard valid/ready rule. They also assume that start and the register inputs change only between clock edges. The bench drives every input at the falling edge. It throttles mTready with several fixed duty patterns, so stalls land on first pixels, line ends and the final pixel. It also moves register values and pulses start in the middle of frames only to show that those actions have no effect until the next launch.

// File: rtl/ovlPkg.sv
package ovlPkg;
  // Strobes from the scan controller to the pixel datapath.
  typedef struct packed {
    logic load;    // capture all settings on this edge
    logic active;  // a frame scan is running
  } ovlStrobe_t;

  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} ovlState_t;
endpackage

// File: rtl/ovlPointHit.sv
module ovlPointHit #(
  parameter int COORD_W = 11
) (
  input  logic [COORD_W-1:0] px,
  input  logic [COORD_W-1:0] py,
  input  logic               en,
  input  logic [COORD_W-1:0] col,
  input  logic [COORD_W-1:0] row,
  input  logic [COORD_W-1:0] size,
  input  logic [COORD_W-1:0] frameCols,
  input  logic [COORD_W-1:0] frameRows,
  output logic               hit
);
  logic [COORD_W-1:0] dx;
  logic [COORD_W-1:0] dy;
  logic               inFrame;

  always_comb begin
    // unsigned magnitude of the distance; no modular wrap possible
    dx      = (col >= px) ? (col - px) : (px - col);
    dy      = (row >= py) ? (row - py) : (py - row);
    inFrame = en && (px < frameCols) && (py < frameRows);
    hit     = inFrame && (dx < size) && (dy < size);
  end
endmodule

// File: rtl/ovlCtrl.sv
module ovlCtrl
  import ovlPkg::*;
#(
  parameter int COORD_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COORD_W-1:0] rowCnt,
  input  logic [COORD_W-1:0] colCnt,
  input  logic               mTready,
  output ovlStrobe_t         strb,
  output logic [COORD_W-1:0] row,
  output logic [COORD_W-1:0] col,
  output logic               mTvalid,
  output logic               mTuser,
  output logic               mTlast,
  output logic               done
);
  localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

  ovlState_t          state;
  logic [COORD_W-1:0] rowLast;
  logic [COORD_W-1:0] colLast;
  logic               launch;
  logic               lineEnd;

  always_comb begin
    launch      = (state == S_IDLE) && start && (rowCnt != '0) && (colCnt != '0);
    strb.load   = launch;
    strb.active = (state == S_RUN);
    lineEnd     = (col == colLast);
    mTvalid     = strb.active;
    mTuser      = strb.active && (row == '0) && (col == '0);
    mTlast      = strb.active && lineEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      row     <= '0;
      col     <= '0;
      rowLast <= '0;
      colLast <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (launch) begin
            state   <= S_RUN;
            row     <= '0;
            col     <= '0;
            rowLast <= rowCnt - ONE;
            colLast <= colCnt - ONE;
            done    <= 1'b0;
          end
        end
        S_RUN: begin
          if (mTready) begin
            if (lineEnd) begin
              col <= '0;
              if (row == rowLast) begin
                state <= S_IDLE;
                done  <= 1'b1;
              end else begin
                row <= row + ONE;
              end
            end else begin
              col <= col + ONE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ovlDatapath.sv
module ovlDatapath
  import ovlPkg::*;
#(
  parameter int NUM_PTS = 20,
  parameter int COORD_W = 11,
  parameter int CHAN_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ovlStrobe_t                 strb,
  input  logic [COORD_W-1:0]         row,
  input  logic [COORD_W-1:0]         col,
  input  logic [COORD_W-1:0]         rowCnt,
  input  logic [COORD_W-1:0]         colCnt,
  input  logic [NUM_PTS*COORD_W-1:0] ptXFlat,
  input  logic [NUM_PTS*COORD_W-1:0] ptYFlat,
  input  logic [NUM_PTS-1:0]         ptEnable,
  input  logic [COORD_W-1:0]         markSize,
  input  logic [3*CHAN_W-1:0]        markColour,
  output logic [4*CHAN_W-1:0]        mTdata
);
  localparam int COLOR_W = 3 * CHAN_W;

  logic [COORD_W-1:0] shRows;
  logic [COORD_W-1:0] shCols;
  logic [COORD_W-1:0] shSize;
  logic [COLOR_W-1:0] shColour;
  logic [NUM_PTS-1:0] shEn;
  logic [NUM_PTS-1:0] hits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shRows   <= '0;
      shCols   <= '0;
      shSize   <= '0;
      shColour <= '0;
      shEn     <= '0;
    end else if (strb.load) begin
      shRows   <= rowCnt;
      shCols   <= colCnt;
      shSize   <= markSize;
      shColour <= markColour;
      shEn     <= ptEnable;
    end
  end

  for (genvar i = 0; i < NUM_PTS; i++) begin : g_pt
    logic [COORD_W-1:0] shX;
    logic [COORD_W-1:0] shY;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shX <= '0;
        shY <= '0;
      end else if (strb.load) begin
        shX <= ptXFlat[i*COORD_W +: COORD_W];
        shY <= ptYFlat[i*COORD_W +: COORD_W];
      end
    end

    ovlPointHit #(.COORD_W(COORD_W)) u_hit (
      .px        (shX),
      .py        (shY),
      .en        (shEn[i]),
      .col       (col),
      .row       (row),
      .size      (shSize),
      .frameCols (shCols),
      .frameRows (shRows),
      .hit       (hits[i])
    );
  end

  always_comb begin
    if (strb.active && (|hits)) mTdata = {{CHAN_W{1'b1}}, shColour};
    else                        mTdata = '0;
  end
endmodule

// File: rtl/scatterOverlay.sv
module scatterOverlay
  import ovlPkg::*;
#(
  parameter int NUM_PTS = 20,
  parameter int COORD_W = 11,
  parameter int CHAN_W  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [COORD_W-1:0]         rowCnt,
  input  logic [COORD_W-1:0]         colCnt,
  input  logic [NUM_PTS*COORD_W-1:0] ptXFlat,
  input  logic [NUM_PTS*COORD_W-1:0] ptYFlat,
  input  logic [NUM_PTS-1:0]         ptEnable,
  input  logic [COORD_W-1:0]         markSize,
  input  logic [3*CHAN_W-1:0]        markColour,
  output logic [4*CHAN_W-1:0]        mTdata,
  output logic                       mTvalid,
  input  logic                       mTready,
  output logic                       mTuser,
  output logic                       mTlast,
  output logic                       done
);
  ovlStrobe_t         strb;
  logic [COORD_W-1:0] row;
  logic [COORD_W-1:0] col;

  ovlCtrl #(.COORD_W(COORD_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rowCnt  (rowCnt),
    .colCnt  (colCnt),
    .mTready (mTready),
    .strb    (strb),
    .row     (row),
    .col     (col),
    .mTvalid (mTvalid),
    .mTuser  (mTuser),
    .mTlast  (mTlast),
    .done    (done)
  );

  ovlDatapath #(.NUM_PTS(NUM_PTS), .COORD_W(COORD_W), .CHAN_W(CHAN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .row        (row),
    .col        (col),
    .rowCnt     (rowCnt),
    .colCnt     (colCnt),
    .ptXFlat    (ptXFlat),
    .ptYFlat    (ptYFlat),
    .ptEnable   (ptEnable),
    .markSize   (markSize),
    .markColour (markColour),
    .mTdata     (mTdata)
  );
endmodule

// File: rtl/scatterOverlayChk.sv
module scatterOverlayChk #(
  parameter int CHAN_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [4*CHAN_W-1:0] mTdata,
  input logic              mTvalid,
  input logic              mTready,
  input logic              mTuser,
  input logic              mTlast,
  input logic              done
);
  // R8: a stalled pixel and its flags are held until taken
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (mTvalid && !mTready) |=> (mTvalid && $stable(mTdata) && $stable(mTuser) && $stable(mTlast)));

  // R5: a pixel is either fully transparent or fully opaque
  a_r5_pixel_format: assert property (@(posedge clk) disable iff (!rstN)
    mTvalid |-> ((mTdata == '0) || (mTdata[4*CHAN_W-1 -: CHAN_W] == {CHAN_W{1'b1}})));

  // R2 / R3: sideband flags appear only with a valid pixel
  a_r2_sideband_valid: assert property (@(posedge clk) disable iff (!rstN)
    (mTuser || mTlast) |-> mTvalid);

  // R10: done is never high while a frame is streaming
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !mTvalid);

  // R10: done rises only right after an accepted line-end pixel
  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(mTvalid && mTready && mTlast));
endmodule

bind scatterOverlay scatterOverlayChk #(.CHAN_W(CHAN_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .mTdata  (mTdata),
  .mTvalid (mTvalid),
  .mTready (mTready),
  .mTuser  (mTuser),
  .mTlast  (mTlast),
  .done    (done)
);

// File: tb/scatterOverlay_bench.sv
module scatterOverlay_bench;
  localparam int NP = 4;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] rowCnt = '0;
  logic [CW-1:0] colCnt = '0;
  logic [NP-1:0][CW-1:0] bX = '0;
  logic [NP-1:0][CW-1:0] bY = '0;
  logic [NP-1:0] ptEnable = '0;
  logic [CW-1:0] markSize = '0;
  logic [23:0] markColour = '0;
  logic [31:0] mTdata;
  logic mTvalid, mTuser, mTlast, done;
  logic mTready = 1'b0;

  // captured configuration, the bench's own model of the launch snapshot
  int capRows, capCols, capSize;
  int capX[NP], capY[NP];
  logic [NP-1:0] capEn;
  logic [23:0] capColour;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  scatterOverlay #(.NUM_PTS(NP), .COORD_W(CW), .CHAN_W(8)) u_scatterOverlay (
    .clk(clk), .rstN(rstN), .start(start), .rowCnt(rowCnt), .colCnt(colCnt),
    .ptXFlat(bX), .ptYFlat(bY), .ptEnable(ptEnable), .markSize(markSize),
    .markColour(markColour), .mTdata(mTdata), .mTvalid(mTvalid), .mTready(mTready),
    .mTuser(mTuser), .mTlast(mTlast), .done(done)
  );

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] expPix(input int r, input int c);
    bit hit = 0;
    for (int i = 0; i < NP; i++) begin
      int dx = c - capX[i];
      int dy = r - capY[i];
      if (dx < 0) dx = -dx;
      if (dy < 0) dy = -dy;
      if (capEn[i] && capX[i] < capCols && capY[i] < capRows && dx < capSize && dy < capSize)
        hit = 1;
    end
    return hit ? {8'hFF, capColour} : 32'h0;
  endfunction

  function automatic bit readyPat(input int mode, input int cyc);
    case (mode)
      1:       return (cyc % 3) != 0;
      2:       return (cyc % 5) >= 2;
      default: return 1'b1;
    endcase
  endfunction

  // Launch a frame, then consume and check every pixel.
  // midEvt: 1 = pulse start mid-frame, 2 = rewrite settings mid-frame.
  task automatic runFrame(input int mode, input int midEvt, input string tag);
    int r = 0, c = 0, cyc = 0;
    bit fin = 0;
    capRows = rowCnt; capCols = colCnt; capSize = markSize;
    capEn = ptEnable; capColour = markColour;
    for (int i = 0; i < NP; i++) begin capX[i] = bX[i]; capY[i] = bY[i]; end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    #1;
    check(done == 1'b0, $sformatf("R10 %s done not cleared by start: %0b exp 0", tag, done));
    while (!fin && cyc < 5000) begin
      mTready = readyPat(mode, cyc);
      start = (midEvt == 1 && cyc == 5);
      if (midEvt == 2 && cyc == 10) begin
        markColour = 24'h00FF00; bX[2] = 6'd8; markSize = 6'd1;
      end
      #1;
      if (!mTvalid) begin
        check(0, $sformatf("R2 %s valid dropped mid-frame r%0d c%0d: 0 exp 1", tag, r, c));
        fin = 1;
      end else begin
        logic [31:0] e = expPix(r, c);
        check(mTdata == e, $sformatf("R5 R4 %s pixel r%0d c%0d: %h exp %h", tag, r, c, mTdata, e));
        check(mTuser == (r == 0 && c == 0),
              $sformatf("R2 %s tuser r%0d c%0d: %0b", tag, r, c, mTuser));
        check(mTlast == (c == capCols - 1),
              $sformatf("R3 %s tlast r%0d c%0d: %0b", tag, r, c, mTlast));
        if (mTready) begin
          if (c == capCols - 1) begin
            c = 0;
            if (r == capRows - 1) fin = 1; else r++;
          end else c++;
        end
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    mTready = 1'b1;
    #1;
    check(done == 1'b1 && mTvalid == 1'b0,
          $sformatf("R10 %s after last pixel done=%0b valid=%0b exp 1 0", tag, done, mTvalid));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!mTvalid && !mTuser && !mTlast && !done,
          $sformatf("R1 reset outputs v%0b u%0b l%0b d%0b exp 0", mTvalid, mTuser, mTlast, done));
    rstN = 1'b1;

    // Frame 1: corners and edge clipping, free-running consumer
    rowCnt = 9; colCnt = 12; markSize = 2; markColour = 24'h12AB34;
    bX[0] = 3;  bY[0] = 2;
    bX[1] = 10; bY[1] = 7;
    bX[2] = 0;  bY[2] = 0;
    bX[3] = 11; bY[3] = 8;
    ptEnable = 4'b1111;
    runFrame(0, 0, "R5 R4 corners");

    // Frame 2: stalls, a disabled point, start ignored mid-frame
    markSize = 1; ptEnable = 4'b1011;
    runFrame(1, 1, "R8 R11 R7 stall");

    // Frame 3: out-of-frame points; settings rewritten mid-frame
    markSize = 3; markColour = 24'hC0FFEE;
    bX[0] = 12; bY[0] = 3;
    bX[1] = 5;  bY[1] = 9;
    bX[2] = 5;  bY[2] = 4;
    bX[3] = 30; bY[3] = 30;
    ptEnable = 4'b1111;
    runFrame(2, 2, "R7 R9 outside");

    // Frame 4: one-column frame picks up the settings written in frame 3
    rowCnt = 3; colCnt = 1;
    bX[0] = 0; bY[0] = 1; ptEnable = 4'b0001;
    runFrame(1, 0, "R9 R3 narrow");
    check(capColour == 24'h00FF00 && capSize == 1,
          $sformatf("R9 frame 4 settings colour %h size %0d exp 00ff00 1", capColour, capSize));

    // Frame 5: size zero draws nothing
    rowCnt = 2; colCnt = 3; markSize = 0;
    bX[0] = 1; bY[0] = 1; ptEnable = 4'b1111;
    runFrame(0, 0, "R6 size0");

    // Zero-count start is ignored: no pixels, done stays set
    rowCnt = 0; colCnt = 4;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(!mTvalid && done, $sformatf("R11 zero rows start valid=%0b done=%0b exp 0 1", mTvalid, done));
    rowCnt = 4; colCnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    #1;
    check(!mTvalid && done, $sformatf("R11 zero cols start valid=%0b done=%0b exp 0 1", mTvalid, done));

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule